// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer reached through a small byte-addressed I/O register bus. Software programs a timeout value, kicks the watchdog by writing the reload register, and can freeze or resume counting with a halt bit. An external tick-enable input, pulsed once per timer period of about 0.6 s, drives a 10-bit down-counter. A timeout in seconds therefore converts to ticks as secs*10/6.

When the counter runs out, the block sets a write-one-to-clear timeout flag and reloads itself for another period. If a second expiry comes before the next reload write, the block also sets a second-timeout flag. Unless the reboot-block input is high, it then raises a one-cycle request to the system for a reset or similar action. A sticky lock bit, two software-event flags set by writes to the data bytes, and a few plain storage registers complete the register file. The bus bridge and the handling of the action request are outside the block.

Top module: `wdt_twostage`

## Requirements
- R1: Reset values are as follows. The timeout value at 0x12 reads 0x0004, control 2 at 0x0A reads 0x0008 and the IRQ-generation byte at 0x10 reads 0x03. Every other location, the counter included, reads 0.
- R2: The register map is: counter/reload word 0x00, data-in byte 0x02, data-out byte 0x03, status 1 word 0x04, status 2 word 0x06, control 1 word 0x08, control 2 word 0x0A, message bytes 0x0C and 0x0D, count byte 0x0E, IRQ-generation byte 0x10, timeout value word 0x12. `bus_size` 0/1/2 selects a 1/2/4-byte access. Bytes are little-endian over consecutive offsets, so a 4-byte read at 0x04 returns status 2 in bits 31:16 and status 1 in bits 15:0, and a 4-byte read at 0x08 returns control 2 above control 1.
- R3: The timeout value keeps only its low 10 bits: writing 0xFFFF reads back 0x03FF.
- R4: Any write to offset 0x00 or 0x01 loads the counter from the timeout value. From the next cycle, offset 0x00 reads that value.
- R5: A cycle with `tick_en` high, halt clear and a non-zero counter decrements the counter. After loading N, the counter reads 1 after N-1 ticks with the timeout flag (status 1 bit 3) still clear. The Nth tick sets that flag and reloads the counter with N.
- R6: Control 1 bit 11 (halt) freezes the counter while set, and counting resumes when it is cleared.
- R7: A counter at 0 ignores ticks and never expires.
- R8: Status bits are write-one-to-clear. Writing 1 to a set bit clears it, and writing 0 leaves it unchanged.
- R9: The second expiry after the last reload write sets status 2 bit 1 as well as the timeout flag. A reload write re-arms the block, so the next expiry counts as a first one again.
- R10: On a second expiry with `reboot_block` low, `action_req` is high for exactly the one cycle after the expiring tick, and status 2 bit 2 (boot flag) sets. With `reboot_block` high, there is no request and no boot flag.
- R11: Control 1 bit 12 (lock) stays set once written to 1, even when 0 is written, until reset.
- R12: A write to data-in sets status 1 bit 1 and a write to data-out sets status 1 bit 2. Both bytes read back the written value.
- R13: When an expiry and a write-one-to-clear of the timeout flag fall in the same cycle, the flag stays set.
- R14: Control 2, both message bytes, the count byte and the IRQ-generation byte read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per timer tick |
| reboot_block | input | 1 | High suppresses the action request |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the access |
| bus_size | input | 2 | 0 byte, 1 word, 2 double word |
| bus_wdata | input | 32 | Write data, low byte at `bus_addr` |
| bus_rdata | output | 32 | Combinational read data |
| action_req | output | 1 | One-cycle request on a second expiry |

## Verification
The assertions assume that `bus_size` never takes the value 3 and that a write covers only implemented locations. They do not otherwise constrain `tick_en`: they guard the counter's decrement, halt and idle behaviour, the sticky lock, and the relation between expiries, flags and the action request. The stimulus uses only sizes 0 to 2. It keeps ticks apart from bus writes except in the one deliberate case where an expiry meets a clear of the timeout flag. The counter sweep steps every timeout value from 1 to 12 through both periods, and alternates `reboot_block` so that both action outcomes are covered.

// File: rtl/wdt_pkg.sv
// Shared constants for the two-stage watchdog: register offsets, bit
// positions and reset values. Assumes the counter is at most 16 bits wide.
package wdt_pkg;
    localparam int CNT_W_DEF  = 10;
    localparam int ADDR_W_DEF = 5;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} bus_size_e;

    localparam int OFS_RELOAD = 'h00;
    localparam int OFS_DIN    = 'h02;
    localparam int OFS_DOUT   = 'h03;
    localparam int OFS_STAT1  = 'h04;
    localparam int OFS_STAT2  = 'h06;
    localparam int OFS_CTL1   = 'h08;
    localparam int OFS_CTL2   = 'h0A;
    localparam int OFS_MSG1   = 'h0C;
    localparam int OFS_MSG2   = 'h0D;
    localparam int OFS_WDCNT  = 'h0E;
    localparam int OFS_IRQGEN = 'h10;
    localparam int OFS_TMO    = 'h12;

    localparam int ST1_SWIN   = 1;
    localparam int ST1_SWOUT  = 2;
    localparam int ST1_TMO    = 3;
    localparam int ST2_SECOND = 1;
    localparam int ST2_BOOT   = 2;
    localparam int CTL1_HALT  = 11;
    localparam int CTL1_LOCK  = 12;

    localparam logic [15:0] CTL2_RST   = 16'h0008;
    localparam logic [7:0]  IRQGEN_RST = 8'h03;
    localparam logic [15:0] TMO_RST    = 16'h0004;
endpackage

// File: rtl/wdt_busport.sv
// Byte-lane decoder for the register bus. Turns an address and a size into
// per-byte write enables with aligned data, and selects read bytes out of a
// flat byte view. Assumes bus_size is never 3 (treated as 4 bytes).
module wdt_busport #(
    parameter int ADDR_W = 5
) (
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    input  logic [8*(2**ADDR_W)-1:0] view,
    output logic [(2**ADDR_W)-1:0]  lane_we,
    output logic [8*(2**ADDR_W)-1:0] lane_data,
    output logic [31:0]             bus_rdata
);
    localparam int NB = 2 ** ADDR_W;
    localparam int VW = 8 * NB;
    localparam int IW = ADDR_W + 1;

    logic [IW-1:0] span_lo, span_hi, nbytes;
    logic [VW-1:0] rsh;
    logic [31:0]   rmask;

    // Access length and byte span covered by this access.
    always_comb begin
        case (bus_size)
            2'd0:    nbytes = IW'(1);
            2'd1:    nbytes = IW'(2);
            default: nbytes = IW'(4);
        endcase
        span_lo = {1'b0, bus_addr};
        span_hi = span_lo + nbytes;
    end

    // One write enable per byte of the register view.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_we[i] = bus_wr && (IW'(i) >= span_lo) && (IW'(i) < span_hi);
    end

    // Write data moved onto the byte lanes starting at the access address.
    assign lane_data = VW'(bus_wdata) << {bus_addr, 3'b000};

    // Read data: bytes from the access address upward, trimmed to the size.
    always_comb begin
        rsh = view >> {bus_addr, 3'b000};
        case (bus_size)
            2'd0:    rmask = 32'h0000_00FF;
            2'd1:    rmask = 32'h0000_FFFF;
            default: rmask = 32'hFFFF_FFFF;
        endcase
        bus_rdata = rsh[31:0] & rmask;
    end

    logic unused_rsh;
    assign unused_rsh = ^rsh[VW-1:32];
endmodule

// File: rtl/wdt_downcount.sv
// Watchdog down-counter. A load copies the timeout value in. Each tick with
// halt clear decrements a non-zero count, and the tick that leaves 1 flags an
// expiry and reloads. Assumes tick is a single-cycle pulse.
module wdt_downcount #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic run;
    assign run    = tick && !halt;
    assign expire = !load && run && (count == CNT_W'(1));

    // Counter update: load first, then decrement or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (run && count != '0)
            count <= (count == CNT_W'(1)) ? load_val : count - CNT_W'(1);
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !halt && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));
    assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && halt) |=> $stable(count));
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/wdt_flags.sv
// Status flags and action request. Status words are write-one-to-clear and
// event sets win over a clear in the same cycle. An expiry while armed (one
// expiry since the last reload) is a second timeout.
module wdt_flags (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        expire,
    input  logic        rearm,
    input  logic        sw_in_evt,
    input  logic        sw_out_evt,
    input  logic [15:0] clr1,
    input  logic [15:0] clr2,
    input  logic        block_action,
    output logic [15:0] st1,
    output logic [15:0] st2,
    output logic        action_req
);
    import wdt_pkg::*;

    logic        armed, second;
    logic [15:0] set1, set2;

    // Event sets for both status words.
    always_comb begin
        second = expire && armed;
        set1 = '0;
        set1[ST1_TMO]   = expire;
        set1[ST1_SWIN]  = sw_in_evt;
        set1[ST1_SWOUT] = sw_out_evt;
        set2 = '0;
        set2[ST2_SECOND] = second;
        set2[ST2_BOOT]   = second && !block_action;
    end

    // Arm on the first expiry, disarm on a reload write.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (rearm) armed <= 1'b0;
        else if (expire) armed <= 1'b1;
    end

    // Status words: clear by writing one, event sets take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= '0;
            st2 <= '0;
        end else begin
            st1 <= (st1 & ~clr1) | set1;
            st2 <= (st2 & ~clr2) | set2;
        end
    end

    // One-cycle action request on an unblocked second timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) action_req <= 1'b0;
        else        action_req <= second && !block_action;
    end

    assert_timeout_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st1[ST1_TMO]);
    assert_second_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && armed) |=> st2[ST2_SECOND]);
    assert_action_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        action_req |-> ($past(expire) && !$past(block_action)));
    assert_action_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        action_req |=> !action_req || $past(expire));
endmodule

// File: rtl/wdt_twostage.sv
// Top of the two-stage watchdog. Holds the control and storage registers,
// assembles the byte view read by the bus, and connects the bus port, the
// counter and the flag logic. Assumes CNT_W <= 16 and ADDR_W >= 5.
module wdt_twostage #(
    parameter int CNT_W  = wdt_pkg::CNT_W_DEF,
    parameter int ADDR_W = wdt_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reboot_block,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              action_req
);
    import wdt_pkg::*;

    localparam int NB = 2 ** ADDR_W;
    localparam int VW = 8 * NB;
    localparam int HALT_B = CTL1_HALT - 8;
    localparam int LOCK_B = CTL1_LOCK - 8;

    logic [NB-1:0]    lane_we;
    logic [VW-1:0]    lane_data, view;
    logic [CNT_W-1:0] count, tmo_q;
    logic             expire, reload_wr;
    logic [15:0]      st1, st2, clr1, clr2, ctl1, ctl2_q, tmo_next;
    logic [7:0]       din_q, dout_q, msg1_q, msg2_q, wdcnt_q, irqgen_q;
    logic             halt_q, lock_q;

    wdt_busport #(.ADDR_W(ADDR_W)) u_bus (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .view     (view),
        .lane_we  (lane_we),
        .lane_data(lane_data),
        .bus_rdata(bus_rdata)
    );

    // Write-derived strobes and clear masks.
    always_comb begin
        reload_wr = lane_we[OFS_RELOAD] || lane_we[OFS_RELOAD+1];
        clr1 = {lane_we[OFS_STAT1+1] ? lane_data[8*(OFS_STAT1+1) +: 8] : 8'h00,
                lane_we[OFS_STAT1]   ? lane_data[8*OFS_STAT1 +: 8]     : 8'h00};
        clr2 = {lane_we[OFS_STAT2+1] ? lane_data[8*(OFS_STAT2+1) +: 8] : 8'h00,
                lane_we[OFS_STAT2]   ? lane_data[8*OFS_STAT2 +: 8]     : 8'h00};
        tmo_next = 16'(tmo_q);
        if (lane_we[OFS_TMO])   tmo_next[7:0]  = lane_data[8*OFS_TMO +: 8];
        if (lane_we[OFS_TMO+1]) tmo_next[15:8] = lane_data[8*(OFS_TMO+1) +: 8];
    end

    // Control register 1: writable halt bit, sticky lock bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (lane_we[OFS_CTL1+1]) begin
            halt_q <= lane_data[8*(OFS_CTL1+1) + HALT_B];
            lock_q <= lock_q | lane_data[8*(OFS_CTL1+1) + LOCK_B];
        end
    end

    // Plain storage registers and the masked timeout value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q    <= '0;
            dout_q   <= '0;
            ctl2_q   <= CTL2_RST;
            msg1_q   <= '0;
            msg2_q   <= '0;
            wdcnt_q  <= '0;
            irqgen_q <= IRQGEN_RST;
            tmo_q    <= CNT_W'(TMO_RST);
        end else begin
            if (lane_we[OFS_DIN])    din_q    <= lane_data[8*OFS_DIN +: 8];
            if (lane_we[OFS_DOUT])   dout_q   <= lane_data[8*OFS_DOUT +: 8];
            if (lane_we[OFS_CTL2])   ctl2_q[7:0]  <= lane_data[8*OFS_CTL2 +: 8];
            if (lane_we[OFS_CTL2+1]) ctl2_q[15:8] <= lane_data[8*(OFS_CTL2+1) +: 8];
            if (lane_we[OFS_MSG1])   msg1_q   <= lane_data[8*OFS_MSG1 +: 8];
            if (lane_we[OFS_MSG2])   msg2_q   <= lane_data[8*OFS_MSG2 +: 8];
            if (lane_we[OFS_WDCNT])  wdcnt_q  <= lane_data[8*OFS_WDCNT +: 8];
            if (lane_we[OFS_IRQGEN]) irqgen_q <= lane_data[8*OFS_IRQGEN +: 8];
            tmo_q <= tmo_next[CNT_W-1:0];
        end
    end

    wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .halt    (halt_q),
        .load    (reload_wr),
        .load_val(tmo_q),
        .count   (count),
        .expire  (expire)
    );

    wdt_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .rearm       (reload_wr),
        .sw_in_evt   (lane_we[OFS_DIN]),
        .sw_out_evt  (lane_we[OFS_DOUT]),
        .clr1        (clr1),
        .clr2        (clr2),
        .block_action(reboot_block),
        .st1         (st1),
        .st2         (st2),
        .action_req  (action_req)
    );

    // Byte view of every location, in offset order, for the read mux.
    always_comb begin
        ctl1 = '0;
        ctl1[CTL1_HALT] = halt_q;
        ctl1[CTL1_LOCK] = lock_q;
        view = '0;
        view[8*OFS_RELOAD +: 16] = 16'(count);
        view[8*OFS_DIN    +: 8]  = din_q;
        view[8*OFS_DOUT   +: 8]  = dout_q;
        view[8*OFS_STAT1  +: 16] = st1;
        view[8*OFS_STAT2  +: 16] = st2;
        view[8*OFS_CTL1   +: 16] = ctl1;
        view[8*OFS_CTL2   +: 16] = ctl2_q;
        view[8*OFS_MSG1   +: 8]  = msg1_q;
        view[8*OFS_MSG2   +: 8]  = msg2_q;
        view[8*OFS_WDCNT  +: 8]  = wdcnt_q;
        view[8*OFS_IRQGEN +: 8]  = irqgen_q;
        view[8*OFS_TMO    +: 16] = 16'(tmo_q);
    end

    logic unused_lanes;
    assign unused_lanes = ^{lane_data, lane_we, tmo_next};

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    assert_reload_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr && !expire) |=> !action_req);
endmodule

// File: tb/sim_wdt_twostage.sv
module sim_wdt_twostage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reboot_block = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        action_req;

    int n_chk = 0;
    int n_fail = 0;
    logic act_seen;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_twostage u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reboot_block(reboot_block),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .action_req(action_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        act_seen = action_req;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        act_seen = action_req;
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] s, output logic [31:0] d);
        bus_addr = a; bus_size = s;
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [1:0] s,
                         input logic [31:0] exp);
        logic [31:0] d;
        rd(a, s, d);
        chk(tag, d, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 dword packing
        rdchk("R1 dword 0x00", 5'h00, 2'd2, 32'h0000_0000);
        rdchk("R1 R2 dword status", 5'h04, 2'd2, 32'h0000_0000);
        rdchk("R1 R2 dword control", 5'h08, 2'd2, 32'h0008_0000);
        rdchk("R1 dword 0x0C", 5'h0C, 2'd2, 32'h0000_0000);
        rdchk("R1 R2 dword 0x10", 5'h10, 2'd2, 32'h0004_0003);

        // R7 idle counter ignores ticks
        tick(); tick();
        rdchk("R7 counter idle", 5'h00, 2'd1, 32'h0);
        rdchk("R7 no flag", 5'h04, 2'd1, 32'h0);

        // R5 R9 R10 sweep over timeout values 1..12
        for (int n = 1; n <= 12; n++) begin
            logic blk;
            blk = n[0];
            reboot_block = blk;
            wr(5'h04, 2'd2, 32'hFFFF_FFFF);
            wr(5'h12, 2'd1, 32'(n));
            wr(5'h00, 2'd1, 32'h0);
            rdchk("R4 load", 5'h00, 2'd1, 32'(n));
            for (int k = 1; k < n; k++) begin
                tick();
                rdchk("R5 decrement", 5'h00, 2'd1, 32'(n - k));
            end
            rdchk("R5 flag clear before expiry", 5'h04, 2'd1, 32'h0);
            tick();
            rdchk("R5 flag on expiry", 5'h04, 2'd1, 32'h8);
            rdchk("R5 reload after expiry", 5'h00, 2'd1, 32'(n));
            chk("R10 no action on first expiry", 32'(act_seen), 32'h0);
            rdchk("R9 no second flag yet", 5'h06, 2'd1, 32'h0);
            for (int k = 1; k <= n; k++) tick();
            rdchk("R9 second flag", 5'h06, 2'd1, blk ? 32'h2 : 32'h6);
            chk("R10 action request", 32'(act_seen), blk ? 32'h0 : 32'h1);
            @(negedge clk);
            chk("R10 action one cycle", 32'(action_req), 32'h0);
        end
        reboot_block = 1'b0;

        // R9 reload re-arms: next expiry is a first one
        wr(5'h04, 2'd2, 32'hFFFF_FFFF);
        wr(5'h12, 2'd1, 32'h3);
        wr(5'h00, 2'd0, 32'h0);
        tick(); tick(); tick();
        rdchk("R9 rearm flag1", 5'h04, 2'd1, 32'h8);
        rdchk("R9 rearm no second", 5'h06, 2'd1, 32'h0);
        chk("R9 rearm no action", 32'(act_seen), 32'h0);

        // R13 expiry beats a same-cycle clear; R8 write-one-to-clear
        wr(5'h04, 2'd2, 32'hFFFF_FFFF);
        wr(5'h12, 2'd1, 32'h2);
        wr(5'h00, 2'd1, 32'h0);
        tick();
        wr_tick(5'h04, 2'd1, 32'h0008);
        rdchk("R13 set wins over clear", 5'h04, 2'd1, 32'h8);
        wr(5'h04, 2'd1, 32'h0000);
        rdchk("R8 zero write keeps flag", 5'h04, 2'd1, 32'h8);
        wr(5'h04, 2'd1, 32'h0008);
        rdchk("R8 one write clears flag", 5'h04, 2'd1, 32'h0);

        // R12 data ports set software flags
        wr(5'h02, 2'd0, 32'h5A);
        rdchk("R12 data-in flag", 5'h04, 2'd1, 32'h2);
        wr(5'h03, 2'd0, 32'hA5);
        rdchk("R12 both flags", 5'h04, 2'd1, 32'h6);
        rdchk("R12 data bytes", 5'h02, 2'd1, 32'hA55A);
        rd(5'h04, 2'd1, d);
        wr(5'h04, 2'd1, d);
        rdchk("R8 write back read value", 5'h04, 2'd1, 32'h0);

        // R6 halt freezes and resumes
        wr(5'h12, 2'd1, 32'd10);
        wr(5'h00, 2'd1, 32'h0);
        wr(5'h09, 2'd0, 32'h08);
        rdchk("R6 halt bit", 5'h08, 2'd1, 32'h0800);
        tick(); tick(); tick();
        rdchk("R6 frozen", 5'h00, 2'd1, 32'd10);
        wr(5'h09, 2'd0, 32'h00);
        tick(); tick();
        rdchk("R6 resumed", 5'h00, 2'd1, 32'd8);

        // R3 timeout mask
        wr(5'h12, 2'd1, 32'hFFFF);
        rdchk("R3 mask", 5'h12, 2'd1, 32'h03FF);
        wr(5'h01, 2'd0, 32'h0);
        rdchk("R3 R4 load masked", 5'h00, 2'd1, 32'h03FF);

        // R14 storage registers, R2 packing
        wr(5'h0A, 2'd1, 32'h1234);
        rdchk("R14 R2 control dword", 5'h08, 2'd2, 32'h1234_0000);
        wr(5'h0C, 2'd0, 32'h11);
        wr(5'h0D, 2'd0, 32'h22);
        wr(5'h0E, 2'd0, 32'h33);
        rdchk("R14 messages and count", 5'h0C, 2'd2, 32'h0033_2211);
        wr(5'h10, 2'd0, 32'h44);
        rdchk("R14 irq gen", 5'h10, 2'd2, 32'h03FF_0044);

        // R11 sticky lock
        wr(5'h08, 2'd1, 32'h1000);
        rdchk("R11 lock set", 5'h08, 2'd1, 32'h1000);
        wr(5'h08, 2'd1, 32'h0000);
        rdchk("R11 lock holds", 5'h08, 2'd1, 32'h1000);
        wr(5'h08, 2'd1, 32'h0800);
        rdchk("R11 lock with halt", 5'h08, 2'd1, 32'h1800);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rdchk("R11 lock cleared by reset", 5'h08, 2'd1, 32'h0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule